// File: doc/BRIEF.md
# Overlay Pixel Alpha Compositor

This block composites one overlay pixel onto one video pixel per clock. The overlay word arrives in one of five packings: palette index, three 16-bit packings, or 32-bit ARGB. It is expanded to 8 bits per channel with an 8-bit local alpha. An optional 16-bit transparent-colour match can turn the pixel fully transparent. The blend weight then comes from one of four sources: the global alpha, the local alpha, the destination alpha, or a scaled product of local and destination alpha. Each channel is mixed with a weighted sum that is divided by 256.

The datapath has two register stages. The first stage holds the expanded overlay colour, the resolved weight and the destination colour. The second stage holds the mixed result. A valid flag travels alongside the data. Inputs may be presented on every cycle, and idle cycles are marked by a low valid flag. The palette is a fixed 256-entry table that is computed from the index, so it needs no loading.

Top module: `osd_blend`

## Requirements
- R1: While reset is active, and on the first sample after it is released, `out_valid` is 0 and `out_pix` is 0.
- R2: `out_valid` equals `in_valid` from two rising clock edges earlier. The `out_pix` value for a pixel appears in that same cycle.
- R3: Narrow channels expand to 8 bits by bit replication. Packings are given as `pix_fmt` codes with their channel fields:
  - code 1 is R[15:11], G[10:5], B[4:0];
  - code 2 is A[15], R[14:10], G[9:5], B[4:0];
  - code 3 is A[15:12], R[11:8], G[7:4], B[3:0];
  - code 4 is A[31:24], R[23:16], G[15:8], B[7:0].
- R4: The local alpha depends on the packing:
  - code 1 has no alpha field and gives 255;
  - code 2 maps its 1-bit alpha to 0 or 255;
  - code 3 replicates its 4-bit alpha (value×17);
  - code 4 uses its 8-bit alpha directly.
- R5: Code 0 uses `osd_pix[7:0]` as a palette index i. The entry has alpha 255, red i, green 255−i, and blue equal to i with its nibbles swapped.
- R6: When `key_en` is 1 and `osd_pix[15:0]` equals `color_key`, the weight is 0. This applies in every packing and weight mode.
- R7: `alpha_mode` selects the weight: 0 gives `global_alpha`, 1 gives the local alpha, 2 gives `dst_alpha`, and 3 gives (local×dst + local)/256, truncated.
- R8: Each output channel is (w×src + (255−w)×dst)/256, truncated. Channels are packed as R[23:16], G[15:8], B[7:0] on both `dst_pix` and `out_pix`.
- R9: The unassigned `pix_fmt` codes 5 to 7 give weight 0 in every weight mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel strobe |
| osd_pix | input | 32 | Overlay pixel word |
| pix_fmt | input | 3 | Overlay packing code |
| alpha_mode | input | 2 | Weight source select |
| global_alpha | input | 8 | Plane-wide weight |
| key_en | input | 1 | Transparent-colour match enable |
| color_key | input | 16 | Transparent colour compared against `osd_pix[15:0]` |
| dst_pix | input | 24 | Video pixel, R/G/B |
| dst_alpha | input | 8 | Video pixel alpha |
| out_valid | output | 1 | Result strobe |
| out_pix | output | 24 | Composited pixel, R/G/B |

## Verification
The bench builds the block with its defaults: 8-bit channels, a 16-bit key and a 256-entry palette. It then sweeps all eight packing codes against all four weight modes. Each combination streams forty hashed pixels, with idle bubbles and with key hits forced on some of them. This reaches every unpack path, every weight source, the reserved codes and the override from the key match, under back-to-back traffic. Directed pixels then pin the extremes of the mixing formula, at weight 0 and weight 255 with saturated colours.

// File: rtl/osd_blend_pkg.sv
package osd_blend_pkg;

    typedef enum logic [2:0] {
        FMT_INDEX = 3'd0,
        FMT_RGB565 = 3'd1,
        FMT_A1RGB5 = 3'd2,
        FMT_ARGB4 = 3'd3,
        FMT_ARGB8 = 3'd4
    } pix_fmt_e;

    typedef enum logic [1:0] {
        WSRC_GLOBAL = 2'd0,
        WSRC_LOCAL = 2'd1,
        WSRC_DEST = 2'd2,
        WSRC_PRODUCT = 2'd3
    } wsrc_e;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } argb_t;

    function automatic logic [7:0] rep4(input logic [3:0] v);
        return {v, v};
    endfunction

    function automatic logic [7:0] rep5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [7:0] rep6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction

endpackage

// File: rtl/osd_palette.sv
module osd_palette #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic [AW-1:0] idx,
    output osd_blend_pkg::argb_t entry
);
    import osd_blend_pkg::*;

    argb_t tbl [DEPTH];

    // Fixed table computed per index: opaque, red ramp, green inverse ramp,
    // blue nibble-swapped index.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_entry
            localparam logic [7:0] IV = 8'(i);
            assign tbl[i] = '{a: 8'hFF, r: IV, g: ~IV, b: {IV[3:0], IV[7:4]}};
        end
    endgenerate

    assign entry = tbl[idx];

endmodule

// File: rtl/osd_unpack.sv
module osd_unpack #(
    parameter int PIX_W = 32,
    parameter int KEY_W = 16,
    parameter int PAL_DEPTH = 256,
    localparam int PAL_AW = $clog2(PAL_DEPTH)
) (
    input  logic [PIX_W-1:0] pix,
    input  logic [2:0] fmt,
    input  logic key_en,
    input  logic [KEY_W-1:0] key,
    output osd_blend_pkg::argb_t px,
    output logic key_hit,
    output logic fmt_ok
);
    import osd_blend_pkg::*;

    argb_t pal_q;

    osd_palette #(.DEPTH(PAL_DEPTH)) u_pal (
        .idx   (pix[PAL_AW-1:0]),
        .entry (pal_q)
    );

    // The key compare always spans the low KEY_W bits, whatever the packing.
    assign key_hit = key_en && (pix[KEY_W-1:0] == key);

    always_comb begin
        px = '0;
        fmt_ok = 1'b1;
        unique case (fmt)
            FMT_INDEX: px = pal_q;
            FMT_RGB565: begin
                px.a = 8'hFF;
                px.r = rep5(pix[15:11]);
                px.g = rep6(pix[10:5]);
                px.b = rep5(pix[4:0]);
            end
            FMT_A1RGB5: begin
                px.a = {8{pix[15]}};
                px.r = rep5(pix[14:10]);
                px.g = rep5(pix[9:5]);
                px.b = rep5(pix[4:0]);
            end
            FMT_ARGB4: begin
                px.a = rep4(pix[15:12]);
                px.r = rep4(pix[11:8]);
                px.g = rep4(pix[7:4]);
                px.b = rep4(pix[3:0]);
            end
            FMT_ARGB8: px = pix[31:0];
            default: fmt_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/osd_alpha_sel.sv
module osd_alpha_sel #(
    parameter int CW = 8,
    localparam int PW = 2 * CW
) (
    input  logic [1:0] mode,
    input  logic [CW-1:0] local_a,
    input  logic [CW-1:0] global_a,
    input  logic [CW-1:0] dest_a,
    input  logic key_hit,
    input  logic fmt_ok,
    output logic [CW-1:0] weight
);
    import osd_blend_pkg::*;

    logic [PW-1:0] prod;

    // local*(dest+1): a full dest gives back the local alpha, a zero dest gives zero
    assign prod = PW'(local_a) * PW'(dest_a) + PW'(local_a);

    always_comb begin
        weight = '0;
        if (fmt_ok && !key_hit) begin
            unique case (wsrc_e'(mode))
                WSRC_GLOBAL: weight = global_a;
                WSRC_LOCAL: weight = local_a;
                WSRC_DEST: weight = dest_a;
                WSRC_PRODUCT: weight = prod[PW-1:CW];
                default: weight = '0;
            endcase
        end
    end

endmodule

// File: rtl/osd_mix.sv
module osd_mix #(
    parameter int CW = 8,
    parameter int NCH = 3,
    localparam int PW = 2 * CW,
    localparam logic [CW-1:0] FULL = '1
) (
    input  logic [CW-1:0] w,
    input  logic [NCH*CW-1:0] src,
    input  logic [NCH*CW-1:0] dst,
    output logic [NCH*CW-1:0] mixed
);

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_lane
            logic [PW-1:0] acc;
            assign acc = PW'(w) * PW'(src[c*CW +: CW])
                       + PW'(FULL - w) * PW'(dst[c*CW +: CW]);
            assign mixed[c*CW +: CW] = acc[PW-1:CW];
        end
    endgenerate

endmodule

// File: rtl/osd_blend.sv
module osd_blend #(
    parameter int CW = 8,
    parameter int PIX_W = 32,
    parameter int KEY_W = 16,
    parameter int PAL_DEPTH = 256,
    localparam int NCH = 3,
    localparam int RGB_W = NCH * CW
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic [PIX_W-1:0] osd_pix,
    input  logic [2:0] pix_fmt,
    input  logic [1:0] alpha_mode,
    input  logic [CW-1:0] global_alpha,
    input  logic key_en,
    input  logic [KEY_W-1:0] color_key,
    input  logic [RGB_W-1:0] dst_pix,
    input  logic [CW-1:0] dst_alpha,
    output logic out_valid,
    output logic [RGB_W-1:0] out_pix
);
    import osd_blend_pkg::*;

    argb_t up_px;
    logic up_key_hit;
    logic up_fmt_ok;
    logic [CW-1:0] sel_w;

    osd_unpack #(
        .PIX_W(PIX_W), .KEY_W(KEY_W), .PAL_DEPTH(PAL_DEPTH)
    ) u_unpack (
        .pix     (osd_pix),
        .fmt     (pix_fmt),
        .key_en  (key_en),
        .key     (color_key),
        .px      (up_px),
        .key_hit (up_key_hit),
        .fmt_ok  (up_fmt_ok)
    );

    osd_alpha_sel #(.CW(CW)) u_asel (
        .mode     (alpha_mode),
        .local_a  (up_px.a),
        .global_a (global_alpha),
        .dest_a   (dst_alpha),
        .key_hit  (up_key_hit),
        .fmt_ok   (up_fmt_ok),
        .weight   (sel_w)
    );

    // stage 1: expanded colour, resolved weight, destination
    logic s1_valid;
    logic [CW-1:0] s1_w;
    logic [RGB_W-1:0] s1_src;
    logic [RGB_W-1:0] s1_dst;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_w <= '0;
            s1_src <= '0;
            s1_dst <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_w <= sel_w;
            s1_src <= {up_px.r, up_px.g, up_px.b};
            s1_dst <= dst_pix;
        end
    end

    logic [RGB_W-1:0] mix_q;

    osd_mix #(.CW(CW), .NCH(NCH)) u_mix (
        .w     (s1_w),
        .src   (s1_src),
        .dst   (s1_dst),
        .mixed (mix_q)
    );

    // stage 2: mixed result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix <= '0;
        end else begin
            out_valid <= s1_valid;
            out_pix <= mix_q;
        end
    end

    // R2: valid flag advances one stage per edge
    a_r2_stage1_valid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_valid);
    a_r2_stage2_valid: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid == $past(s1_valid) |=> out_valid == $past(s1_valid));

    // R6: key match yields zero weight at stage 1
    a_r6_key_clears_weight: assert property (@(posedge clk) disable iff (!rst_n)
        (key_en && osd_pix[KEY_W-1:0] == color_key) |=> s1_w == '0);

    // R4: opaque packing with local weight gives full weight
    a_r4_rgb565_opaque: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_fmt == 3'd1 && alpha_mode == 2'd1 && !(key_en && osd_pix[KEY_W-1:0] == color_key))
        |=> s1_w == '1);

    // R9: reserved packing codes yield zero weight
    a_r9_reserved_fmt: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_fmt > 3'd4) |=> s1_w == '0);

    // R8: zero weight never brightens the destination
    a_r8_zero_weight_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_w == '0) |=> out_pix[CW-1:0] <= $past(s1_dst[CW-1:0]));

endmodule

// File: tb/osd_blend_test.sv
module osd_blend_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [31:0] osd_pix = '0;
    logic [2:0] pix_fmt = '0;
    logic [1:0] alpha_mode = '0;
    logic [7:0] global_alpha = '0;
    logic key_en = 1'b0;
    logic [15:0] color_key = '0;
    logic [23:0] dst_pix = '0;
    logic [7:0] dst_alpha = '0;
    logic out_valid;
    logic [23:0] out_pix;

    int total = 0;
    int bad = 0;

    logic exp_v [2];
    logic [23:0] exp_d [2];
    string exp_t [2];

    always #10 clk = ~clk;

    osd_blend uut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .osd_pix (osd_pix),
        .pix_fmt (pix_fmt), .alpha_mode (alpha_mode), .global_alpha (global_alpha),
        .key_en (key_en), .color_key (color_key), .dst_pix (dst_pix),
        .dst_alpha (dst_alpha), .out_valid (out_valid), .out_pix (out_pix)
    );

    function automatic logic [23:0] model(
        input logic [31:0] p, input int f, input int am, input int ga,
        input logic [15:0] k, input logic ke, input logic [23:0] d, input int da);
        int r, g, b, la, w, x;
        int o [3];
        int s [3];
        int dd [3];
        r = 0; g = 0; b = 0; la = 0;
        case (f)
            0: begin x = int'(p[7:0]); la = 255; r = x; g = 255 - x; b = (x % 16) * 16 + x / 16; end
            1: begin
                x = int'(p[15:11]); r = x * 8 + x / 4;
                x = int'(p[10:5]);  g = x * 4 + x / 16;
                x = int'(p[4:0]);   b = x * 8 + x / 4;
                la = 255;
            end
            2: begin
                la = p[15] ? 255 : 0;
                x = int'(p[14:10]); r = x * 8 + x / 4;
                x = int'(p[9:5]);   g = x * 8 + x / 4;
                x = int'(p[4:0]);   b = x * 8 + x / 4;
            end
            3: begin
                la = int'(p[15:12]) * 17; r = int'(p[11:8]) * 17;
                g = int'(p[7:4]) * 17;    b = int'(p[3:0]) * 17;
            end
            4: begin la = int'(p[31:24]); r = int'(p[23:16]); g = int'(p[15:8]); b = int'(p[7:0]); end
            default: ;
        endcase
        case (am)
            0: w = ga;
            1: w = la;
            2: w = da;
            default: w = (la * da + la) / 256;
        endcase
        if (f > 4 || (ke && p[15:0] == k)) w = 0;
        s[0] = r; s[1] = g; s[2] = b;
        dd[0] = int'(d[23:16]); dd[1] = int'(d[15:8]); dd[2] = int'(d[7:0]);
        for (int c = 0; c < 3; c++) o[c] = (w * s[c] + (255 - w) * dd[c]) / 256;
        return {o[0][7:0], o[1][7:0], o[2][7:0]};
    endfunction

    task automatic check_outputs();
        total++;
        if (out_valid !== exp_v[1]) begin
            bad++;
            $display("FAIL R2 %s out_valid actual=%0b expected=%0b", exp_t[1], out_valid, exp_v[1]);
        end
        if (exp_v[1]) begin
            total++;
            if (out_pix !== exp_d[1]) begin
                bad++;
                $display("FAIL %s out_pix actual=%06h expected=%06h", exp_t[1], out_pix, exp_d[1]);
            end
        end
    endtask

    task automatic cycle(input logic v, input logic [31:0] p, input int f, input int am,
                         input int ga, input logic ke, input logic [15:0] k,
                         input logic [23:0] d, input int da, input string tag);
        @(negedge clk);
        check_outputs();
        exp_v[1] = exp_v[0]; exp_d[1] = exp_d[0]; exp_t[1] = exp_t[0];
        in_valid = v; osd_pix = p; pix_fmt = 3'(f); alpha_mode = 2'(am);
        global_alpha = 8'(ga); key_en = ke; color_key = k; dst_pix = d; dst_alpha = 8'(da);
        exp_v[0] = v;
        exp_d[0] = model(p, f, am, ga, k, ke, d, da);
        exp_t[0] = tag;
    endtask

    function automatic logic [31:0] mixh(input int seed);
        logic [31:0] h;
        h = 32'(seed) * 32'h9E3779B1;
        return h ^ (h >> 13) ^ (h << 7);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        exp_v[0] = 1'b0; exp_v[1] = 1'b0;
        exp_d[0] = '0; exp_d[1] = '0;
        exp_t[0] = "R1"; exp_t[1] = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || out_pix !== 24'h0) begin
            bad++;
            $display("FAIL R1 reset state actual=%0b/%06h expected=0/000000", out_valid, out_pix);
        end
        rst_n = 1'b1;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b0 || out_pix !== 24'h0) begin
            bad++;
            $display("FAIL R1 after release actual=%0b/%06h expected=0/000000", out_valid, out_pix);
        end

        // sweep every packing against every weight source
        for (int f = 0; f < 8; f++) begin
            for (int am = 0; am < 4; am++) begin
                for (int n = 0; n < 40; n++) begin
                    logic [31:0] p;
                    logic [31:0] q;
                    logic ke;
                    logic [15:0] k;
                    string tag;
                    p = mixh(f * 1000 + am * 100 + n);
                    q = mixh(p[15:0] + 7);
                    ke = (n % 5 == 0);
                    k = (n % 10 == 0) ? p[15:0] : q[31:16];
                    if (ke && p[15:0] == k) tag = "R6";
                    else if (f > 4) tag = "R9";
                    else if (f == 0) tag = "R5";
                    else if (am != 1) tag = "R7";
                    else if (f == 1) tag = "R3";
                    else tag = "R4";
                    cycle(n % 7 != 3, p, f, am, int'(q[7:0]), ke, k, q[31:8], int'(p[23:16]), tag);
                end
            end
        end

        // mixing extremes (R8): full and zero weight, saturated colours
        cycle(1'b1, 32'h00FFFFFF, 4, 0, 255, 1'b0, 16'h0, 24'h000000, 0, "R8");
        cycle(1'b1, 32'h00FFFFFF, 4, 0, 0, 1'b0, 16'h0, 24'hFF8001, 0, "R8");
        cycle(1'b1, 32'h00123456, 4, 0, 128, 1'b0, 16'h0, 24'h654321, 0, "R8");
        cycle(1'b1, 32'hFF000000, 4, 1, 0, 1'b0, 16'h0, 24'hFFFFFF, 0, "R8");
        // product weight corners (R7)
        cycle(1'b1, 32'h80FFFFFF, 4, 3, 0, 1'b0, 16'h0, 24'h000000, 255, "R7");
        cycle(1'b1, 32'hFFFFFFFF, 4, 3, 0, 1'b0, 16'h0, 24'h000000, 0, "R7");
        // one-bit alpha both ways (R4), keyed 565 pixel (R6)
        cycle(1'b1, 32'h0000FFFF, 2, 1, 0, 1'b0, 16'h0, 24'h102030, 0, "R4");
        cycle(1'b1, 32'h00007FFF, 2, 1, 0, 1'b0, 16'h0, 24'h102030, 0, "R4");
        cycle(1'b1, 32'h0000F800, 1, 1, 0, 1'b1, 16'hF800, 24'h0A0B0C, 0, "R6");
        for (int i = 0; i < 3; i++)
            cycle(1'b0, 32'h0, 0, 0, 0, 1'b0, 16'h0, 24'h0, 0, "R2");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule